// File: doc/BRIEF.md
# Escaped Extraction Word Encoder

This block sits between a switch queue and a CPU that pulls frames out one 32-bit word at a time. The queue side delivers a stream of beats. Each beat carries one word plus marks for frame start, frame end, an abort and a prune, and a count of unused bytes in a final word. The beats are held in a small word FIFO. On the read side, each read strobe returns exactly one word: either payload, or a reserved code that carries frame-level information in-band.

Frame ends, the number of valid bytes in the last word, aborts and prunes are all signalled by reserved codes. A code is always followed by one raw data word. A payload word that happens to look like a reserved code is sent behind an escape code, so the reader can never mistake it for one. A read with nothing queued returns a not-ready code. A status bit tells the CPU that at least one complete frame is waiting. A two-bit flush control throws away everything queued while either bit is set.

Top module: `xtr_stream_encoder`

## Requirements
- R1: Each read strobe (`rd_en` high at a clock edge) consumes exactly one output word. Ordinary payload words come out in arrival order, unchanged. `rd_data` shows the word that the next read will consume.
- R2: Reserved code k (k = 0..7) has the value 0x80000000+k. On `rd_data` it appears byte-reversed, as 0x0k000080.
- R3: A beat with `in_eof` and `in_pad` = p is read out as the end code k = p, followed by the beat's word. That word holds 4-p valid bytes.
- R4: A mid-frame payload word equal to any of the eight byte-reversed code values is read out as the escape code (k = 6) followed by the raw word. The word that follows any code is never escaped.
- R5: A beat with `in_prune` is read out as the prune code (k = 4) followed by its word, and that word ends the frame.
- R6: A beat with `in_abort` is read out as the abort code (k = 5) followed by its word, and the frame ends as aborted. On the same beat, abort wins over prune and prune wins over end.
- R7: A read when no word is available returns the not-ready code (k = 7) and consumes nothing.
- R8: `data_present` is 1 exactly when flush is off and at least one frame is queued whose final beat has been accepted but whose last word has not yet been read.
- R9: While either bit of `flush_ctl` is 1, all queued words and any half-read code pair are discarded. During that time `data_present` is 0, `rd_data` shows not-ready, `in_ready` is 1, and accepted beats are dropped.
- R10: After a flush, accepted beats are dropped until one arrives with `in_sof`. From that beat on, normal queuing resumes.
- R11: `in_ready` is 0 only when flush is off and DEPTH beats are queued. A beat is taken only when `in_valid` and `in_ready` are both 1.
- R12: After reset the queue is empty, `data_present` is 0, `in_ready` is 1 and `rd_data` shows not-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Beat offered by the queue |
| in_ready | output | 1 | Beat can be taken this cycle |
| in_sof | input | 1 | Beat starts a frame |
| in_eof | input | 1 | Beat ends a frame normally |
| in_pad | input | 2 | Unused bytes in the final word (0..3) |
| in_prune | input | 1 | Beat ends a pruned frame |
| in_abort | input | 1 | Beat ends an aborted frame |
| in_data | input | 32 | Beat word, in read-port byte order |
| flush_ctl | input | 2 | Flush request; any bit set discards |
| rd_en | input | 1 | Read strobe, consumes one output word |
| rd_data | output | 32 | Word returned by the current read |
| data_present | output | 1 | A complete frame is waiting |

## Verification
Several properties hold on every cycle and are checked by assertions. The FIFO never overflows or underflows. A pending trailing word always has a queued beat behind it. A flush leaves the queue and the frame count at zero by the next cycle. A non-zero frame count always has queued data behind it. What the assertions cannot show is the exact word sequence a reader sees. That includes the code chosen for each beat type, escaping of colliding payload but not of trailing words, the priority among abort, prune and end, and dropping beats after a flush until a frame start. Those come only from the bench. It replays directed and random beat and read patterns against a behavioural word-queue model.

// File: rtl/xtr_enc_pkg.sv
// Shared types and helpers for the extraction word encoder.
// Assumes the read port presents words with byte 0 in bits 7:0.
package xtr_enc_pkg;

    typedef enum logic [1:0] {
        BEAT_MID   = 2'd0,
        BEAT_END   = 2'd1,
        BEAT_PRUNE = 2'd2,
        BEAT_ABORT = 2'd3
    } beat_kind_e;

    typedef struct packed {
        beat_kind_e  kind;
        logic [1:0]  pad;
        logic [31:0] word;
    } beat_t;

    localparam logic [31:0] CODE_BASE   = 32'h8000_0000;
    localparam logic [2:0]  IDX_PRUNE   = 3'd4;
    localparam logic [2:0]  IDX_ABORT   = 3'd5;
    localparam logic [2:0]  IDX_ESCAPE  = 3'd6;
    localparam logic [2:0]  IDX_NOTRDY  = 3'd7;

    // Reverse byte order of a word (network order on the port).
    function automatic logic [31:0] byte_rev(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    // Port value of reserved code number idx.
    function automatic logic [31:0] code_word(input logic [2:0] idx);
        return byte_rev(CODE_BASE | {29'd0, idx});
    endfunction

    // True when a payload word looks like any reserved code on the port.
    function automatic logic clashes(input logic [31:0] w);
        return (w[31:27] == 5'd0) && (w[23:8] == 16'd0) && (w[7:0] == 8'h80);
    endfunction

endpackage

// File: rtl/xtr_word_fifo.sv
// Synchronous FIFO of beat entries.
// Assumes DEPTH is a power of two; clear empties it in one cycle.
module xtr_word_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [AW:0]      cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == FULL_CNT);
    assign rdata = mem[rd_ptr];

    // Store an entry on push.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
        end
    end

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);

endmodule

// File: rtl/xtr_ingress.sv
// Accepts queue beats, classifies them and handles post-flush dropping.
// Assumes a beat with abort, prune or eof is the last of its frame.
module xtr_ingress
    import xtr_enc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush_on,
    input  logic        fifo_full,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic [1:0]  in_pad,
    input  logic        in_prune,
    input  logic        in_abort,
    input  logic [31:0] in_data,
    output logic        in_ready,
    output logic        push,
    output beat_t       push_beat,
    output logic        push_ends
);
    logic dropping;
    logic accept;

    assign in_ready  = flush_on || !fifo_full;
    assign accept    = in_valid && in_ready;
    assign push      = accept && !flush_on && (!dropping || in_sof);
    assign push_ends = push && (push_beat.kind != BEAT_MID);

    // Classify the beat, abort first, then prune, then end.
    always_comb begin
        push_beat.word = in_data;
        push_beat.pad  = in_pad;
        if (in_abort)      push_beat.kind = BEAT_ABORT;
        else if (in_prune) push_beat.kind = BEAT_PRUNE;
        else if (in_eof)   push_beat.kind = BEAT_END;
        else               push_beat.kind = BEAT_MID;
    end

    // Drop beats from a flush until the next frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)                dropping <= 1'b0;
        else if (flush_on)         dropping <= 1'b1;
        else if (accept && in_sof) dropping <= 1'b0;
    end

endmodule

// File: rtl/xtr_encoder.sv
// Read side: turns the head beat into one or two port words.
// Assumes the head entry stays in the FIFO until its last word is read.
module xtr_encoder
    import xtr_enc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush_on,
    input  beat_t       head,
    input  logic        fifo_empty,
    input  logic        rd_en,
    output logic [31:0] rd_data,
    output logic        pop,
    output logic        pop_ends
);
    logic       trail_q;
    logic       advance;
    logic [2:0] prefix;

    // Pick the code index that precedes the head word.
    always_comb begin
        unique case (head.kind)
            BEAT_END:   prefix = {1'b0, head.pad};
            BEAT_PRUNE: prefix = IDX_PRUNE;
            BEAT_ABORT: prefix = IDX_ABORT;
            default:    prefix = IDX_ESCAPE;
        endcase
    end

    // Select the current port word and whether a read consumes the head.
    always_comb begin
        rd_data = code_word(IDX_NOTRDY);
        pop     = 1'b0;
        advance = 1'b0;
        if (!flush_on && !fifo_empty) begin
            if (trail_q || (head.kind == BEAT_MID && !clashes(head.word))) begin
                rd_data = head.word;
                pop     = rd_en;
            end else begin
                rd_data = code_word(prefix);
                advance = rd_en;
            end
        end
    end

    assign pop_ends = pop && (head.kind != BEAT_MID);

    // Track that a code was read and its word is next.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_on) trail_q <= 1'b0;
        else if (advance)       trail_q <= 1'b1;
        else if (pop)           trail_q <= 1'b0;
    end

    // R4
    trail_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trail_q |-> !fifo_empty);

endmodule

// File: rtl/xtr_stream_encoder.sv
// Top: escaped extraction word encoder with frame-present status and flush.
// Assumes one CPU group; rd_data is valid combinationally while rd_en is sampled.
module xtr_stream_encoder
    import xtr_enc_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic [1:0]  in_pad,
    input  logic        in_prune,
    input  logic        in_abort,
    input  logic [31:0] in_data,
    input  logic [1:0]  flush_ctl,
    input  logic        rd_en,
    output logic [31:0] rd_data,
    output logic        data_present
);
    localparam int unsigned BW = $bits(beat_t);
    localparam int unsigned FW = $clog2(DEPTH + 1);

    logic          flush_on;
    logic          push, push_ends, pop, pop_ends;
    logic          fifo_empty, fifo_full;
    beat_t         push_beat;
    logic [BW-1:0] head_bits;
    logic [FW-1:0] frame_cnt;

    assign flush_on     = |flush_ctl;
    assign data_present = !flush_on && (frame_cnt != '0);

    xtr_ingress u_ingress (
        .clk, .rst_n, .flush_on, .fifo_full,
        .in_valid, .in_sof, .in_eof, .in_pad, .in_prune, .in_abort, .in_data,
        .in_ready, .push, .push_beat, .push_ends
    );

    xtr_word_fifo #(.DEPTH(DEPTH), .WIDTH(BW)) u_fifo (
        .clk, .rst_n, .clear(flush_on),
        .push, .wdata(push_beat), .pop, .rdata(head_bits),
        .empty(fifo_empty), .full(fifo_full)
    );

    xtr_encoder u_encoder (
        .clk, .rst_n, .flush_on, .head(beat_t'(head_bits)), .fifo_empty,
        .rd_en, .rd_data, .pop, .pop_ends
    );

    // Count complete frames held in the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_on) frame_cnt <= '0;
        else frame_cnt <= frame_cnt + {{(FW-1){1'b0}}, push_ends}
                                    - {{(FW-1){1'b0}}, pop_ends};
    end

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_on |=> (fifo_empty && frame_cnt == '0));
    // R8
    present_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_cnt != '0) |-> !fifo_empty);

endmodule

// File: tb/tb_xtr_stream_encoder.sv
module tb_xtr_stream_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 0, in_sof = 0, in_eof = 0, in_prune = 0, in_abort = 0;
    logic [1:0]  in_pad = 0;
    logic [31:0] in_data = 0;
    logic [1:0]  flush_ctl = 0;
    logic        rd_en = 0;
    logic        in_ready, data_present;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model: expected port words, with per-word marks.
    logic [31:0] exp_q[$];
    bit          beat_q[$];   // word completes a queued beat
    bit          end_q[$];    // word completes a frame
    bit          drop = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xtr_stream_encoder #(.DEPTH(DEPTH)) dut (
        .clk, .rst_n, .in_valid, .in_ready, .in_sof, .in_eof, .in_pad,
        .in_prune, .in_abort, .in_data, .flush_ctl, .rd_en, .rd_data, .data_present
    );

    function automatic logic [31:0] port_code(int k);
        logic [31:0] v = 32'h8000_0000 + k;
        return {<<8{v}};
    endfunction

    function automatic bit is_code(logic [31:0] w);
        for (int k = 0; k < 8; k++) if (w == port_code(k)) return 1;
        return 0;
    endfunction

    function automatic int count_marks(ref bit q[$]);
        int n = 0;
        foreach (q[i]) n += q[i];
        return n;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic add_word(logic [31:0] w, bit b, bit e);
        exp_q.push_back(w); beat_q.push_back(b); end_q.push_back(e);
    endtask

    // One clock: drive at negedge, compare, then advance the model.
    task automatic cycle(bit v, bit sof, bit eof, bit [1:0] pad, bit prune, bit abrt,
                         logic [31:0] d, bit rd, bit [1:0] fl, string tag);
        bit fon, rdy;
        @(negedge clk);
        in_valid = v; in_sof = sof; in_eof = eof; in_pad = pad; in_prune = prune;
        in_abort = abrt; in_data = d; rd_en = rd; flush_ctl = fl;
        #1;
        fon = (fl != 0);
        rdy = fon || (count_marks(beat_q) < DEPTH);
        check(tag, "rd_data", rd_data, (fon || exp_q.size() == 0) ? port_code(7) : exp_q[0]);
        check(tag, "in_ready", {31'd0, in_ready}, {31'd0, rdy});
        check(tag, "data_present", {31'd0, data_present},
              {31'd0, !fon && count_marks(end_q) > 0});
        if (fon) begin
            exp_q.delete(); beat_q.delete(); end_q.delete();
            drop = 1;
        end else begin
            if (rd && exp_q.size() > 0) begin
                void'(exp_q.pop_front()); void'(beat_q.pop_front()); void'(end_q.pop_front());
            end
            if (v && rdy) begin
                if (!drop || sof) begin
                    if (abrt)       begin add_word(port_code(5), 0, 0); add_word(d, 1, 1); end
                    else if (prune) begin add_word(port_code(4), 0, 0); add_word(d, 1, 1); end
                    else if (eof)   begin add_word(port_code(int'(pad)), 0, 0); add_word(d, 1, 1); end
                    else if (is_code(d)) begin add_word(port_code(6), 0, 0); add_word(d, 1, 0); end
                    else add_word(d, 1, 0);
                end
                if (sof) drop = 0;
            end
        end
    endtask

    task automatic beat(logic [31:0] d, bit sof, bit eof, bit [1:0] pad, bit prune, bit abrt,
                        bit rd, string tag);
        cycle(1, sof, eof, pad, prune, abrt, d, rd, 2'b00, tag);
    endtask

    task automatic reads(int n, string tag);
        for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, 0, 32'h0, 1, 2'b00, tag);
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R12: reset state
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 2'b00, "R12 reset");
        // R7: empty reads
        reads(3, "R7 not-ready");
        // R1 / R3: plain frame, full last word, then pad 2
        beat(32'h1111_2222, 1, 0, 0, 0, 0, 0, "R1 data");
        beat(32'h3333_4444, 0, 0, 0, 0, 0, 0, "R1 data");
        beat(32'h5555_6666, 0, 1, 0, 0, 0, 0, "R3 eof0");
        beat(32'hAABB_CC00, 1, 1, 2, 0, 0, 0, "R3 eof2");
        reads(8, "R1 R3 R8 readout");
        // R2 / R4: colliding payload escaped, trailing word not escaped
        beat(32'h0300_0080, 1, 0, 0, 0, 0, 0, "R2 R4 escape");
        beat(32'h0700_0080, 0, 0, 0, 0, 0, 0, "R4 escape");
        beat(32'h0500_0080, 0, 1, 3, 0, 0, 0, "R4 raw trailer");
        reads(8, "R2 R4 readout");
        // R5 / R6: prune, abort, and priority on one beat
        beat(32'h0000_00AA, 1, 0, 0, 1, 0, 0, "R5 prune");
        beat(32'h0000_00BB, 1, 0, 0, 0, 1, 1, "R6 abort");
        beat(32'h0000_00CC, 1, 1, 1, 1, 1, 1, "R6 priority");
        beat(32'h0000_00DD, 1, 1, 1, 1, 0, 1, "R6 prune over end");
        reads(8, "R5 R6 readout");
        // R11: fill the queue without reading
        for (int i = 0; i < DEPTH + 3; i++) beat(32'h100 + i, i == 0, 0, 0, 0, 0, 0, "R11 fill");
        reads(2, "R11 drain one");
        beat(32'h0000_0999, 0, 1, 0, 0, 0, 0, "R11 refill");
        reads(DEPTH + 4, "R11 drain");
        // R9 / R10: flush mid-frame, then drop until a frame start
        beat(32'hDEAD_0001, 1, 0, 0, 0, 0, 0, "R9 pre");
        beat(32'hDEAD_0002, 0, 1, 0, 0, 0, 1, "R9 pre");
        cycle(1, 0, 1, 0, 0, 0, 32'hDEAD_0003, 1, 2'b01, "R9 flush bit0");
        cycle(1, 1, 0, 0, 0, 0, 32'hDEAD_0004, 1, 2'b10, "R9 flush bit1");
        beat(32'hBEEF_0001, 0, 0, 0, 0, 0, 0, "R10 dropped");
        beat(32'hBEEF_0002, 0, 1, 0, 0, 0, 1, "R10 dropped");
        beat(32'hBEEF_0003, 1, 1, 1, 0, 0, 0, "R10 resume");
        reads(4, "R10 readout");
        // Random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] d;
            int r = $urandom % 100;
            d = ($urandom % 4 == 0) ? {5'd0, 3'($urandom), 16'd0, 8'h80} : $urandom;
            cycle($urandom % 3 != 0, $urandom % 4 == 0, $urandom % 4 == 0, 2'($urandom),
                  $urandom % 16 == 0, $urandom % 16 == 0, d, $urandom % 2 == 0,
                  (r < 2) ? 2'($urandom % 3 + 1) : 2'b00, "rand R1 R4 R8 R11");
        end
        reads(3 * DEPTH, "rand R8 drain");
        done = 1;
        summary();
        $finish;
    end
endmodule